// File: doc/BRIEF.md
# Programmable Power-of-Two Frequency Divider

This block divides a count stream by a power of two chosen from a 5-bit programming code. It has two count-clock inputs. A rising edge on either input advances the divider only while the other input is low, so each input also acts as a gate for the other. Both count clocks are slow relative to the system clock `clk`. They are brought through synchronizer flops and edge-detected, and each accepted edge advances a 31-bit binary count. That count is the synchronous equivalent of a ripple chain that is fed from a fixed quarter-rate line.

The main output is a square wave whose period is 2^N accepted edges for code N. Codes 0 and 1 switch every output off. Three auxiliary outputs give fixed ratios of their own that depend on the code. Some codes hold an auxiliary output low. The programming code is captured while the asynchronous active-low clear is held. The clear also restarts the count from zero and forces every output low at once.

Top module: `pow2_divider`

## Requirements
- R1: For code N from 2 to 31, `divOut` is a 50% square wave with a period of 2^N accepted count edges. It first rises after 2^(N-1) edges following a clear.
- R2: For codes 0 and 1, `divOut` and all three `auxOut` bits stay low whatever the count inputs do.
- R3: A rising edge on `cntClkA` while `cntClkB` is low is one accepted count edge.
- R4: A rising edge on `cntClkB` while `cntClkA` is low is one accepted count edge.
- R5: While either count input is high, edges on the other input are ignored and the count holds.
- R6: While `chainClrN` is low, all outputs are low at once and asynchronously. Release restarts the count from zero.
- R7: `auxOut[0]` has these exponents. Codes 2 to 21 give 9. Codes 22 and 23 hold it low. Codes 24/25, 26/27, 28/29 and 30/31 give 3, 5, 7 and 9.
- R8: `auxOut[1]` has these exponents. Codes 2 to 13 give 17. Codes 14 and 15 hold it low. From code 16, each even/odd code pair gives exponents 3, 5, 7, ... up to 17 at codes 30/31.
- R9: `auxOut[2]` has these exponents. Codes 2 to 7 give 24. From code 8, each even/odd code pair gives exponents 2, 4, 6, ... up to 24 at codes 30/31.
- R10: `progCode` is captured only while `chainClrN` is low. A change during counting has no effect until the next clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the count inputs |
| chainClrN | input | 1 | Asynchronous active-low clear; captures the code while low |
| cntClkA | input | 1 | First count clock, gated by `cntClkB` |
| cntClkB | input | 1 | Second count clock, gated by `cntClkA` |
| progCode | input | 5 | Ratio selection code, captured during clear |
| divOut | output | 1 | Main divided output, ratio 2^code |
| auxOut | output | 3 | Auxiliary divided outputs, each with its own mapping per code |

## Verification
A wrong count value or a mis-decoded code shows up as a phase or period error on the output whose exponent covers the faulty bit. For short ratios the error appears within a few accepted edges. For the ratio-2^9 and ratio-2^10 taps it appears within the first few hundred edges. A gating fault (an edge accepted while the other input is high) moves `divOut` off its expected phase on the next edges that are checked. A fault in code capture makes the whole output pattern follow the wrong code from the first edges after a clear. The bench therefore compares all four outputs after every accepted edge, for every code, against a count it keeps on its own.

// File: rtl/pow2_div_pkg.sv
package pow2_div_pkg;

  localparam int OUT_N = 4;

  typedef struct packed {
    logic count;  // one accepted count edge this cycle
    logic load;   // capture programming code
  } strobe_t;

  // Exponent of the ratio for output sel (0 = main, 1..3 = auxiliary).
  // Zero means the output is held low.
  function automatic logic [5:0] mapExp(input int sel, input logic [4:0] code);
    int c;
    int e;
    c = int'(code);
    e = 0;
    if (c >= 2) begin
      case (sel)
        0: e = c;
        1: begin
          if (c >= 24)      e = 3 + ((c - 24) >> 1) * 2;
          else if (c >= 22) e = 0;
          else              e = 9;
        end
        2: begin
          if (c >= 16)      e = 3 + ((c - 16) >> 1) * 2;
          else if (c >= 14) e = 0;
          else              e = 17;
        end
        default: begin
          if (c >= 8) e = 2 + ((c - 8) >> 1) * 2;
          else        e = 24;
        end
      endcase
    end
    return 6'(e);
  endfunction

endpackage

// File: rtl/pow2_div_ctrl.sv
module pow2_div_ctrl #(
  parameter int SYNC_N = 2
) (
  input  logic                  clk,
  input  logic                  clrN,
  input  logic                  cntClkA,
  input  logic                  cntClkB,
  output pow2_div_pkg::strobe_t stb
);

  logic [SYNC_N-1:0] syncA;
  logic [SYNC_N-1:0] syncB;
  logic              prevA;
  logic              prevB;
  logic              lvlA;
  logic              lvlB;

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) begin
      syncA <= '0;
      syncB <= '0;
      prevA <= 1'b0;
      prevB <= 1'b0;
    end else begin
      syncA <= {syncA[SYNC_N-2:0], cntClkA};
      syncB <= {syncB[SYNC_N-2:0], cntClkB};
      prevA <= lvlA;
      prevB <= lvlB;
    end
  end

  assign lvlA = syncA[SYNC_N-1];
  assign lvlB = syncB[SYNC_N-1];

  always_comb begin
    stb.count = (lvlA & ~prevA & ~lvlB) | (lvlB & ~prevB & ~lvlA);
    stb.load  = ~clrN;
  end

endmodule

// File: rtl/pow2_div_dp.sv
module pow2_div_dp #(
  parameter int CNT_W  = 31,
  parameter int CODE_W = 5,
  parameter int OUT_N  = 4
) (
  input  logic                  clk,
  input  logic                  clrN,
  input  pow2_div_pkg::strobe_t stb,
  input  logic [CODE_W-1:0]     progCode,
  output logic [CNT_W-1:0]      cnt,
  output logic [CODE_W-1:0]     codeReg,
  output logic [OUT_N-1:0]      outVec
);

  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) cnt <= '0;
    else if (stb.count) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (stb.load) codeReg <= progCode;
  end

  for (genvar g = 0; g < OUT_N; g++) begin : g_out
    logic [5:0]     expV;
    logic [CNT_W:0] shifted;
    assign expV       = pow2_div_pkg::mapExp(g, codeReg);
    // Bit expV-1 of the count; exponent zero lands on the padding zero.
    assign shifted    = {cnt, 1'b0} >> expV;
    assign outVec[g]  = clrN & shifted[0];
  end

endmodule

// File: rtl/pow2_divider.sv
module pow2_divider #(
  parameter int CNT_W  = 31,
  parameter int CODE_W = 5,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              chainClrN,
  input  logic              cntClkA,
  input  logic              cntClkB,
  input  logic [CODE_W-1:0] progCode,
  output logic              divOut,
  output logic [2:0]        auxOut
);

  localparam int OUT_N = pow2_div_pkg::OUT_N;

  pow2_div_pkg::strobe_t stb;
  logic [CNT_W-1:0]      cntVal;
  logic [CODE_W-1:0]     curCode;
  logic [OUT_N-1:0]      outVec;
  logic                  countStb;

  pow2_div_ctrl #(.SYNC_N(SYNC_N)) ctrl_i (
    .clk     (clk),
    .clrN    (chainClrN),
    .cntClkA (cntClkA),
    .cntClkB (cntClkB),
    .stb     (stb)
  );

  pow2_div_dp #(.CNT_W(CNT_W), .CODE_W(CODE_W), .OUT_N(OUT_N)) dp_i (
    .clk      (clk),
    .clrN     (chainClrN),
    .stb      (stb),
    .progCode (progCode),
    .cnt      (cntVal),
    .codeReg  (curCode),
    .outVec   (outVec)
  );

  assign countStb = stb.count;
  assign divOut   = outVec[0];
  assign auxOut   = outVec[3:1];

endmodule

// File: rtl/pow2_div_chk.sv
module pow2_div_chk #(
  parameter int CNT_W  = 31,
  parameter int CODE_W = 5
) (
  input logic              clk,
  input logic              clearN,
  input logic              countStb,
  input logic [CNT_W-1:0]  cnt,
  input logic [CODE_W-1:0] curCode,
  input logic              divOut,
  input logic [2:0]        auxOut
);

  // R6: clear forces every output low
  a_r6_clear_low: assert property (@(posedge clk)
    !clearN |-> (divOut == 1'b0 && auxOut == 3'b000));

  // R2: inhibit codes keep all outputs low
  a_r2_inhibit_code: assert property (@(posedge clk) disable iff (!clearN)
    (curCode < 2) |-> (divOut == 1'b0 && auxOut == 3'b000));

  // R3: an accepted edge advances the count by exactly one
  a_r3_count_step: assert property (@(posedge clk) disable iff (!clearN)
    countStb |=> (cnt == $past(cnt) + 1'b1));

  // R5: without an accepted edge the count holds
  a_r5_hold: assert property (@(posedge clk) disable iff (!clearN)
    !countStb |=> $stable(cnt));

  // R1: outputs move only on accepted edges
  a_r1_out_steady: assert property (@(posedge clk) disable iff (!clearN)
    !countStb |=> ($stable(divOut) && $stable(auxOut)));

  // R7: codes 22 and 23 hold the first auxiliary output low
  a_r7_aux0_off: assert property (@(posedge clk) disable iff (!clearN)
    (curCode == 5'd22 || curCode == 5'd23) |-> (auxOut[0] == 1'b0));

  // R8: codes 14 and 15 hold the second auxiliary output low
  a_r8_aux1_off: assert property (@(posedge clk) disable iff (!clearN)
    (curCode == 5'd14 || curCode == 5'd15) |-> (auxOut[1] == 1'b0));

  // R10: the captured code holds outside clear
  a_r10_code_kept: assert property (@(posedge clk) disable iff (!clearN)
    1'b1 |=> $stable(curCode));

endmodule

bind pow2_divider pow2_div_chk #(.CNT_W(CNT_W), .CODE_W(CODE_W)) chk_i (
  .clk      (clk),
  .clearN   (chainClrN),
  .countStb (countStb),
  .cnt      (cntVal),
  .curCode  (curCode),
  .divOut   (divOut),
  .auxOut   (auxOut)
);

// File: tb/pow2_divider_tb_top.sv
`timescale 1ns/1ps
module pow2_divider_tb_top;

  logic       clk = 1'b0;
  logic       chainClrN = 1'b0;
  logic       cntClkA = 1'b0;
  logic       cntClkB = 1'b0;
  logic [4:0] progCode = 5'd0;
  logic       divOut;
  logic [2:0] auxOut;

  int checks = 0;
  int failures = 0;
  int pCount = 0;
  int modelCode = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pow2_divider dut_i (
    .clk       (clk),
    .chainClrN (chainClrN),
    .cntClkA   (cntClkA),
    .cntClkB   (cntClkB),
    .progCode  (progCode),
    .divOut    (divOut),
    .auxOut    (auxOut)
  );

  // Expected exponent per output, written from the requirements.
  function automatic int benchExp(int o, int c);
    if (c < 2) return 0;
    case (o)
      0: return c;
      1: begin
        if (c < 22) return 9;
        if (c < 24) return 0;
        return c - (c % 2) - 21;
      end
      2: begin
        if (c < 14) return 17;
        if (c < 16) return 0;
        return c - (c % 2) - 13;
      end
      default: begin
        if (c < 8) return 24;
        return c - (c % 2) - 6;
      end
    endcase
  endfunction

  function automatic int expBit(int o, int c, int p);
    int e;
    e = benchExp(o, c);
    if (e == 0) return 0;
    return (p >> (e - 1)) & 1;
  endfunction

  function automatic int actBit(int o);
    if (o == 0) return int'(divOut);
    return int'(auxOut[o-1]);
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doClear(int code);
    @(negedge clk);
    chainClrN = 1'b0;
    progCode = 5'(code);
    cntClkA = 1'b0;
    cntClkB = 1'b0;
    repeat (3) @(negedge clk);
    chainClrN = 1'b1;
    modelCode = code;
    pCount = 0;
  endtask

  // One high/low pulse on input A (useB=0) or B (useB=1), then settle.
  task automatic pulse(bit useB);
    bit other;
    other = useB ? cntClkA : cntClkB;
    @(negedge clk);
    if (useB) cntClkB = 1'b1; else cntClkA = 1'b1;
    repeat (2) @(negedge clk);
    if (useB) cntClkB = 1'b0; else cntClkA = 1'b0;
    repeat (2) @(negedge clk);
    if (!other) pCount++;
  endtask

  // Compare main output over n pulses; one aggregated check.
  task automatic runMain(string req, int n, bit useB);
    int bad;
    int firstAct;
    int firstExp;
    bad = 0; firstAct = 0; firstExp = 0;
    for (int k = 0; k < n; k++) begin
      pulse(useB);
      if (actBit(0) != expBit(0, modelCode, pCount)) begin
        if (bad == 0) begin
          firstAct = actBit(0);
          firstExp = expBit(0, modelCode, pCount);
        end
        bad++;
      end
    end
    if (bad != 0) check(req, firstAct, firstExp);
    else check(req, 0, 0);
  endtask

  initial begin
    repeat (200000 - 10000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R6: reset state
    repeat (3) @(negedge clk);
    check("R6 reset divOut", int'(divOut), 0);
    check("R6 reset auxOut", int'(auxOut), 0);

    // R1 R2 R7 R8 R9: sweep every code, compare all outputs per edge (R3 drive)
    for (int code = 0; code < 32; code++) begin
      int bad[4];
      int fa[4];
      int fe[4];
      doClear(code);
      for (int o = 0; o < 4; o++) begin bad[o] = 0; fa[o] = 0; fe[o] = 0; end
      for (int k = 0; k < 700; k++) begin
        pulse(1'b0);
        for (int o = 0; o < 4; o++) begin
          if (actBit(o) != expBit(o, code, pCount)) begin
            if (bad[o] == 0) begin
              fa[o] = actBit(o);
              fe[o] = expBit(o, code, pCount);
            end
            bad[o]++;
          end
        end
      end
      check($sformatf("R1/R2/R3 main code=%0d", code), fa[0], fe[0]);
      check($sformatf("R7 aux0 code=%0d", code), fa[1], fe[1]);
      check($sformatf("R8 aux1 code=%0d", code), fa[2], fe[2]);
      check($sformatf("R9 aux2 code=%0d", code), fa[3], fe[3]);
    end

    // R4: counting through input B
    doClear(3);
    runMain("R4 count via B", 40, 1'b1);

    // R5: B high gates A edges
    doClear(2);
    runMain("R5 pre-gate", 5, 1'b0);
    @(negedge clk); cntClkB = 1'b1;
    repeat (4) @(negedge clk);
    pCount++;  // B rose while A low: one edge
    for (int k = 0; k < 3; k++) pulse(1'b0);
    @(negedge clk); cntClkB = 1'b0;
    repeat (4) @(negedge clk);
    check("R5 hold under B", int'(divOut), expBit(0, 2, pCount));
    runMain("R5 resume after B gate", 8, 1'b0);

    // R5: A high gates B edges
    @(negedge clk); cntClkA = 1'b1;
    repeat (4) @(negedge clk);
    pCount++;  // A rose while B low: one edge
    for (int k = 0; k < 3; k++) pulse(1'b1);
    @(negedge clk); cntClkA = 1'b0;
    repeat (4) @(negedge clk);
    check("R5 hold under A", int'(divOut), expBit(0, 2, pCount));
    runMain("R5 resume after A gate", 8, 1'b1);

    // R6: clear in the middle of a count
    doClear(3);
    runMain("R1 before mid clear", 6, 1'b0);
    check("R1 divOut high at 6 edges", int'(divOut), 1);
    @(negedge clk);
    chainClrN = 1'b0;
    progCode = 5'd4;
    #1;
    check("R6 async clear divOut", int'(divOut), 0);
    check("R6 async clear auxOut", int'(auxOut), 0);
    repeat (3) @(negedge clk);
    chainClrN = 1'b1;
    modelCode = 4;
    pCount = 0;
    runMain("R6 restart from zero", 20, 1'b0);

    // R10: code change without clear has no effect
    progCode = 5'd2;
    runMain("R10 code ignored without clear", 20, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule